// File: doc/BRIEF.md
# Unlock Command Sequence Decoder

This block sits on the write side of a byte-wide nonvolatile memory and watches every accepted bus write for multi-byte unlock sequences. Each sequence opens with the same two bytes, AA written at 5555 and then 55 written at 2AAA. The third byte either selects a command directly or, when it is 80, leads into a second AA/55 pair whose final byte selects a further command. The commands it recognises are a protected page write, protection disable, chip erase, identification entry (two forms) and identification exit.

The block holds three pieces of state. The first is a global write-protect flag, which is clear after reset. The second is an identification-mode flag, which makes reads at the two lowest addresses return the manufacturer code and the device code. The third is a lockout timer, started when a bare write hits a protected device. While the lockout timer runs, every write is dropped. After a protected-write command, or after any plain write while protection is off, a page-load window opens. Every write inside that window is passed on as a page-buffer byte, and each such byte restarts the window timer.

Top module: `unlock_seq_decoder`

## Requirements
- R1: After synchronous reset, the following outputs are all low: load_stb_o, page_load_en_o, erase_start_o, protect_o, id_mode_o, lockout_o and id_rdata_o.
- R2: The sequence AA@5555, 55@2AAA, A0@5555 sets protect_o and raises page_load_en_o. While the window is open, each accepted write gives a one-cycle load_stb_o pulse in the cycle after the write.
- R3: page_load_en_o stays high for exactly WIN_CYC cycles after the last write that opened or refilled the window.
- R4: The sequence AA, 55, 80, AA, 55, 20 (addresses 5555, 2AAA, 5555, 5555, 2AAA, 5555) clears protect_o.
- R5: The same six-write sequence ending in 10 gives a single-cycle erase_start_o pulse and leaves protect_o unchanged.
- R6: The three-write sequence ending in 90 sets id_mode_o. The one ending in F0 clears it. The six-write sequence ending in 60 also sets it.
- R7: While id_mode_o is set and address bits 14..1 are zero, id_rdata_o gives MFR_CODE (BF) when bit 0 is 0 and DEV_CODE when bit 0 is 1. In every other case id_rdata_o is 00. The value appears one cycle after the address.
- R8: Only address bits 14..0 take part in sequence matching and in the identification lookup. Bits 16..15 are ignored.
- R9: A write that does not continue a sequence while protect_o is set is rejected. It gives no load_stb_o and it raises lockout_o for exactly LOCK_CYC cycles. Writes during the lockout change no state.
- R10: While protect_o is clear, a write that does not continue a sequence ends the sequence. It is then treated as a data byte: load_stb_o pulses and the window opens.
- R11: A write strobe is ignored while oe_i is high or cs_i is low.
- R12: protect_o stays set after the page-load window closes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_i | input | 1 | Chip select, active high |
| oe_i | input | 1 | Output enable, active high; blocks writes |
| wr_stb_i | input | 1 | Write strobe, one cycle per bus write |
| addr_i | input | ADDR_W (17) | Bus address |
| data_i | input | DATA_W (8) | Write data |
| load_stb_o | output | 1 | Pulse: the previous write is a page-buffer byte |
| page_load_en_o | output | 1 | Page-load window open |
| erase_start_o | output | 1 | Pulse: chip erase requested |
| protect_o | output | 1 | Global write protection state |
| id_mode_o | output | 1 | Identification mode state |
| lockout_o | output | 1 | Writes dropped after a rejected write |
| id_rdata_o | output | DATA_W (8) | Identification read data |

## Verification
A vector table drives complete sequences for each command, in order, and checks the flags after every write. This shows that the shared AA/55 prefix branches on the third byte and, for the 80 path, on the sixth byte. The same table uses addresses with bits 16..15 set, bare writes in the protected and unprotected states, and a sequence broken in the middle. These separate a rejection that starts a lockout from a fallback to a data byte. Directed tests count window and lockout lengths cycle by cycle, show that a refill restarts the window, show that gated strobes leave a half-finished sequence untouched, sweep the identification addresses, and apply reset while state is held.

// File: rtl/usd_pkg.sv
package usd_pkg;
  localparam int unsigned KEY_W = 15;
  localparam logic [KEY_W-1:0] ADR_HI = 15'h5555;
  localparam logic [KEY_W-1:0] ADR_LO = 15'h2AAA;
  localparam logic [7:0] BYTE_UNL1 = 8'hAA;
  localparam logic [7:0] BYTE_UNL2 = 8'h55;
  localparam logic [7:0] OP_PROT   = 8'hA0;
  localparam logic [7:0] OP_EXT    = 8'h80;
  localparam logic [7:0] OP_IDIN   = 8'h90;
  localparam logic [7:0] OP_IDOUT  = 8'hF0;
  localparam logic [7:0] OP_UNPROT = 8'h20;
  localparam logic [7:0] OP_ERASE  = 8'h10;
  localparam logic [7:0] OP_IDALT  = 8'h60;

  typedef enum logic [2:0] {
    ST_IDLE, ST_P1, ST_P2, ST_X3, ST_X4, ST_X5
  } seq_st_t;

  typedef struct packed {
    logic unl1;   // first unlock byte at the high key address
    logic unl2;   // second unlock byte at the low key address
    logic at_hi;  // address equals the high key address
  } byte_cls_t;
endpackage

// File: rtl/usd_match.sv
module usd_match
  import usd_pkg::*;
#(
  parameter int unsigned CMP_W  = 15,
  parameter int unsigned DATA_W = 8
) (
  input  logic [CMP_W-1:0]  addr_i,
  input  logic [DATA_W-1:0] data_i,
  output byte_cls_t         cls_o
);
  logic hi_hit, lo_hit;
  assign hi_hit = (addr_i == CMP_W'(ADR_HI));
  assign lo_hit = (addr_i == CMP_W'(ADR_LO));

  always_comb begin
    cls_o.at_hi = hi_hit;
    cls_o.unl1  = hi_hit && (data_i == DATA_W'(BYTE_UNL1));
    cls_o.unl2  = lo_hit && (data_i == DATA_W'(BYTE_UNL2));
  end
endmodule

// File: rtl/usd_timer.sv
module usd_timer #(
  parameter int unsigned N = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic load_i,
  output logic active_o
);
  localparam int unsigned CW = (N < 2) ? 1 : $clog2(N + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                cnt <= '0;
    else if (load_i)        cnt <= CW'(N);
    else if (cnt != '0)     cnt <= cnt - CW'(1);
  end

  assign active_o = (cnt != '0);
endmodule

// File: rtl/usd_seq_fsm.sv
module usd_seq_fsm
  import usd_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_i,
  input  logic              win_i,
  input  byte_cls_t         cls_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              load_stb_o,
  output logic              erase_o,
  output logic              prot_o,
  output logic              id_o,
  output logic              open_o,
  output logic              rej_o
);
  seq_st_t st, st_n;
  logic prot_n, id_n, ld_n, er_n, plain;

  always_comb begin
    st_n   = st;
    prot_n = prot_o;
    id_n   = id_o;
    ld_n   = 1'b0;
    er_n   = 1'b0;
    open_o = 1'b0;
    plain  = 1'b0;
    if (acc_i) begin
      if (win_i) begin
        ld_n   = 1'b1;
        open_o = 1'b1;
      end else begin
        st_n = ST_IDLE;
        unique case (st)
          ST_IDLE: if (cls_i.unl1) st_n = ST_P1; else plain = 1'b1;
          ST_P1:   if (cls_i.unl2) st_n = ST_P2; else plain = 1'b1;
          ST_X3:   if (cls_i.unl1) st_n = ST_X4; else plain = 1'b1;
          ST_X4:   if (cls_i.unl2) st_n = ST_X5; else plain = 1'b1;
          ST_P2: begin
            if (!cls_i.at_hi) plain = 1'b1;
            else if (data_i == DATA_W'(OP_PROT)) begin
              prot_n = 1'b1;
              open_o = 1'b1;
            end
            else if (data_i == DATA_W'(OP_EXT))   st_n = ST_X3;
            else if (data_i == DATA_W'(OP_IDIN))  id_n = 1'b1;
            else if (data_i == DATA_W'(OP_IDOUT)) id_n = 1'b0;
            else plain = 1'b1;
          end
          ST_X5: begin
            if (!cls_i.at_hi) plain = 1'b1;
            else if (data_i == DATA_W'(OP_UNPROT)) prot_n = 1'b0;
            else if (data_i == DATA_W'(OP_ERASE))  er_n = 1'b1;
            else if (data_i == DATA_W'(OP_IDALT))  id_n = 1'b1;
            else plain = 1'b1;
          end
          default: st_n = ST_IDLE;
        endcase
        if (plain && !prot_o) begin
          ld_n   = 1'b1;
          open_o = 1'b1;
        end
      end
    end
    rej_o = plain && prot_o;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      prot_o     <= 1'b0;
      id_o       <= 1'b0;
      load_stb_o <= 1'b0;
      erase_o    <= 1'b0;
    end else begin
      st         <= st_n;
      prot_o     <= prot_n;
      id_o       <= id_n;
      load_stb_o <= ld_n;
      erase_o    <= er_n;
    end
  end
endmodule

// File: rtl/usd_id_rom.sv
module usd_id_rom #(
  parameter int unsigned CMP_W  = 15,
  parameter int unsigned DATA_W = 8,
  parameter logic [DATA_W-1:0] MFR_CODE = 8'hBF,
  parameter logic [DATA_W-1:0] DEV_CODE = 8'h07
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              id_i,
  input  logic [CMP_W-1:0]  addr_i,
  output logic [DATA_W-1:0] rdata_o
);
  always_ff @(posedge clk) begin
    if (rst)
      rdata_o <= '0;
    else if (id_i && (addr_i[CMP_W-1:1] == '0))
      rdata_o <= addr_i[0] ? DEV_CODE : MFR_CODE;
    else
      rdata_o <= '0;
  end
endmodule

// File: rtl/unlock_seq_decoder.sv
module unlock_seq_decoder
  import usd_pkg::*;
#(
  parameter int unsigned ADDR_W   = 17,
  parameter int unsigned CMP_W    = 15,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned LOCK_CYC = 75000,
  parameter int unsigned WIN_CYC  = 50000,
  parameter logic [DATA_W-1:0] MFR_CODE = 8'hBF,
  parameter logic [DATA_W-1:0] DEV_CODE = 8'h07
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_i,
  input  logic              oe_i,
  input  logic              wr_stb_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              load_stb_o,
  output logic              page_load_en_o,
  output logic              erase_start_o,
  output logic              protect_o,
  output logic              id_mode_o,
  output logic              lockout_o,
  output logic [DATA_W-1:0] id_rdata_o
);
  logic [CMP_W-1:0] key_addr;
  logic             unused_hi;
  logic             acc, open_w, rej_w;
  byte_cls_t        cls;

  assign key_addr  = addr_i[CMP_W-1:0];
  assign unused_hi = ^addr_i[ADDR_W-1:CMP_W];
  assign acc       = wr_stb_i && cs_i && !oe_i && !lockout_o;

  usd_match #(.CMP_W(CMP_W), .DATA_W(DATA_W)) match_i (
    .addr_i(key_addr), .data_i(data_i), .cls_o(cls)
  );

  usd_seq_fsm #(.DATA_W(DATA_W)) fsm_i (
    .clk(clk), .rst(rst), .acc_i(acc), .win_i(page_load_en_o),
    .cls_i(cls), .data_i(data_i),
    .load_stb_o(load_stb_o), .erase_o(erase_start_o),
    .prot_o(protect_o), .id_o(id_mode_o),
    .open_o(open_w), .rej_o(rej_w)
  );

  usd_timer #(.N(WIN_CYC)) win_tmr_i (
    .clk(clk), .rst(rst), .load_i(open_w), .active_o(page_load_en_o)
  );

  usd_timer #(.N(LOCK_CYC)) lock_tmr_i (
    .clk(clk), .rst(rst), .load_i(rej_w), .active_o(lockout_o)
  );

  usd_id_rom #(.CMP_W(CMP_W), .DATA_W(DATA_W),
               .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)) rom_i (
    .clk(clk), .rst(rst), .id_i(id_mode_o), .addr_i(key_addr),
    .rdata_o(id_rdata_o)
  );
endmodule

// File: rtl/usd_checker.sv
module usd_checker #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              cs_i,
  input logic              oe_i,
  input logic              load_stb_o,
  input logic              page_load_en_o,
  input logic              erase_start_o,
  input logic              protect_o,
  input logic              id_mode_o,
  input logic              lockout_o,
  input logic [DATA_W-1:0] id_rdata_o
);
  p_load_in_win_r2: assert property (@(posedge clk) disable iff (rst)
    load_stb_o |-> page_load_en_o);
  p_prot_opens_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(protect_o) |-> page_load_en_o);
  p_win_hold_r3: assert property (@(posedge clk) disable iff (rst)
    load_stb_o |=> page_load_en_o);
  p_unprot_closed_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(protect_o) |-> !page_load_en_o);
  p_erase_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    erase_start_o |=> !erase_start_o);
  p_id_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    !id_mode_o |=> (id_rdata_o == '0));
  p_lock_needs_prot_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(lockout_o) |-> protect_o);
  p_lock_blocks_r9: assert property (@(posedge clk) disable iff (rst)
    lockout_o |=> (!load_stb_o && !erase_start_o &&
                   $stable(protect_o) && $stable(id_mode_o)));
  p_gated_r11: assert property (@(posedge clk) disable iff (rst)
    (!cs_i || oe_i) |=> (!load_stb_o && !erase_start_o &&
                         $stable(protect_o) && $stable(id_mode_o) &&
                         !$rose(lockout_o) && !$rose(page_load_en_o)));
  p_keep_prot_r12: assert property (@(posedge clk) disable iff (rst)
    $fell(page_load_en_o) |-> $stable(protect_o));
endmodule

bind unlock_seq_decoder usd_checker #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst(rst), .cs_i(cs_i), .oe_i(oe_i),
  .load_stb_o(load_stb_o), .page_load_en_o(page_load_en_o),
  .erase_start_o(erase_start_o), .protect_o(protect_o),
  .id_mode_o(id_mode_o), .lockout_o(lockout_o), .id_rdata_o(id_rdata_o)
);

// File: tb/unlock_seq_decoder_tb_top.sv
module unlock_seq_decoder_tb_top;
  localparam int unsigned LOCK = 20;
  localparam int unsigned WIN  = 16;
  localparam logic [7:0]  DEV  = 8'h07;
  localparam int NROW = 36;
  // row: addr[42:26] data[25:18] exp{ld,pe,pr,id,er,lk}[17:12] gap[11:4] req[3:0]
  localparam logic [42:0] TBL [NROW] = '{
    {17'h05555, 8'hAA, 6'b000000, 8'd0,  4'd6},   // R6 prefix
    {17'h02AAA, 8'h55, 6'b000000, 8'd0,  4'd6},
    {17'h05555, 8'h90, 6'b000100, 8'd0,  4'd6},   // R6 entry
    {17'h15555, 8'hAA, 6'b000100, 8'd0,  4'd8},   // R8 bit16 set
    {17'h0AAAA, 8'h55, 6'b000100, 8'd0,  4'd8},   // R8 bit15 set
    {17'h05555, 8'hF0, 6'b000000, 8'd0,  4'd8},   // R8 exit recognised
    {17'h05555, 8'hAA, 6'b000000, 8'd0,  4'd6},
    {17'h02AAA, 8'h55, 6'b000000, 8'd0,  4'd6},
    {17'h05555, 8'h80, 6'b000000, 8'd0,  4'd6},
    {17'h05555, 8'hAA, 6'b000000, 8'd0,  4'd6},
    {17'h02AAA, 8'h55, 6'b000000, 8'd0,  4'd6},
    {17'h05555, 8'h60, 6'b000100, 8'd0,  4'd6},   // R6 alternate entry
    {17'h05555, 8'hAA, 6'b000100, 8'd0,  4'd6},
    {17'h02AAA, 8'h55, 6'b000100, 8'd0,  4'd6},
    {17'h05555, 8'hF0, 6'b000000, 8'd0,  4'd6},   // R6 exit
    {17'h00100, 8'h12, 6'b110000, 8'd20, 4'd10},  // R10 bare write unprotected
    {17'h05555, 8'hAA, 6'b000000, 8'd0,  4'd2},
    {17'h02AAA, 8'h55, 6'b000000, 8'd0,  4'd2},
    {17'h05555, 8'hA0, 6'b011000, 8'd0,  4'd2},   // R2 protect + window
    {17'h00180, 8'h34, 6'b111000, 8'd20, 4'd2},   // R2 data byte
    {17'h00200, 8'h56, 6'b001001, 8'd0,  4'd9},   // R9 rejected
    {17'h05555, 8'hAA, 6'b001001, 8'd24, 4'd9},   // R9 ignored in lockout
    {17'h05555, 8'hAA, 6'b001000, 8'd0,  4'd5},
    {17'h02AAA, 8'h55, 6'b001000, 8'd0,  4'd5},
    {17'h05555, 8'h80, 6'b001000, 8'd0,  4'd5},
    {17'h05555, 8'hAA, 6'b001000, 8'd0,  4'd5},
    {17'h02AAA, 8'h55, 6'b001000, 8'd0,  4'd5},
    {17'h05555, 8'h10, 6'b001010, 8'd0,  4'd5},   // R5 erase pulse
    {17'h05555, 8'hAA, 6'b001000, 8'd0,  4'd4},   // R5 pulse gone, R4 start
    {17'h02AAA, 8'h55, 6'b001000, 8'd0,  4'd4},
    {17'h05555, 8'h80, 6'b001000, 8'd0,  4'd4},
    {17'h05555, 8'hAA, 6'b001000, 8'd0,  4'd4},
    {17'h02AAA, 8'h55, 6'b001000, 8'd0,  4'd4},
    {17'h05555, 8'h20, 6'b000000, 8'd0,  4'd4},   // R4 disable
    {17'h05555, 8'hAA, 6'b000000, 8'd0,  4'd10},
    {17'h00300, 8'h77, 6'b110000, 8'd20, 4'd10}   // R10 mismatch as data
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cs_i = 1'b1, oe_i = 1'b0, wr_stb_i = 1'b0;
  logic [16:0] addr_i = '0;
  logic [7:0]  data_i = '0;
  logic        load_stb_o, page_load_en_o, erase_start_o;
  logic        protect_o, id_mode_o, lockout_o;
  logic [7:0]  id_rdata_o;
  int          n_chk = 0;
  int          n_fail = 0;

  always #2 clk = ~clk;

  unlock_seq_decoder #(.LOCK_CYC(LOCK), .WIN_CYC(WIN), .DEV_CODE(DEV)) dut_i (
    .clk(clk), .rst(rst), .cs_i(cs_i), .oe_i(oe_i), .wr_stb_i(wr_stb_i),
    .addr_i(addr_i), .data_i(data_i), .load_stb_o(load_stb_o),
    .page_load_en_o(page_load_en_o), .erase_start_o(erase_start_o),
    .protect_o(protect_o), .id_mode_o(id_mode_o), .lockout_o(lockout_o),
    .id_rdata_o(id_rdata_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [16:0] a, input logic [7:0] d,
                      input logic cs = 1'b1, input logic oe = 1'b0);
    @(negedge clk);
    addr_i = a; data_i = d; cs_i = cs; oe_i = oe; wr_stb_i = 1'b1;
    @(negedge clk);
    wr_stb_i = 1'b0; cs_i = 1'b1; oe_i = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [5:0] flags();
    return {load_stb_o, page_load_en_o, protect_o, id_mode_o, erase_start_o, lockout_o};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int cnt;
    idle(3);
    rst = 1'b0;
    idle(1);
    check("R1 reset flags", 32'(flags()), 32'd0);
    check("R1 reset id data", 32'(id_rdata_o), 32'd0);

    for (int i = 0; i < NROW; i++) begin
      send(TBL[i][42:26], TBL[i][25:18]);
      check($sformatf("R%0d row %0d", TBL[i][3:0], i), 32'(flags()), 32'(TBL[i][17:12]));
      idle(int'(TBL[i][11:4]));
    end

    // R7 identification readout, R8 upper bits ignored
    send(17'h05555, 8'hAA); send(17'h02AAA, 8'h55); send(17'h05555, 8'h90);
    addr_i = 17'h00000; idle(1);
    check("R7 manufacturer code", 32'(id_rdata_o), 32'hBF);
    addr_i = 17'h00001; idle(1);
    check("R7 device code", 32'(id_rdata_o), 32'(DEV));
    addr_i = 17'h18001; idle(1);
    check("R8 device code upper bits", 32'(id_rdata_o), 32'(DEV));
    addr_i = 17'h00002; idle(1);
    check("R7 other address", 32'(id_rdata_o), 32'h00);
    send(17'h05555, 8'hAA); send(17'h02AAA, 8'h55); send(17'h05555, 8'hF0);
    addr_i = 17'h00000; idle(1);
    check("R7 after exit", 32'(id_rdata_o), 32'h00);

    // R11 gated strobes
    send(17'h00400, 8'h11, 1'b1, 1'b1);
    check("R11 oe gated write", 32'({load_stb_o, page_load_en_o}), 32'd0);
    send(17'h00400, 8'h11, 1'b0, 1'b0);
    check("R11 cs gated write", 32'({load_stb_o, page_load_en_o}), 32'd0);
    send(17'h05555, 8'hAA); send(17'h02AAA, 8'h55);
    send(17'h05555, 8'h90, 1'b1, 1'b1);
    check("R11 gated command", 32'(id_mode_o), 32'd0);
    send(17'h05555, 8'h90);
    check("R11 sequence kept", 32'(id_mode_o), 32'd1);
    send(17'h05555, 8'hAA); send(17'h02AAA, 8'h55); send(17'h05555, 8'hF0);

    // R3 window length and refill
    send(17'h00500, 8'h22);
    cnt = 0;
    for (int k = 0; k < 40; k++) begin
      if (page_load_en_o) cnt++;
      @(negedge clk);
    end
    check("R3 window length", 32'(cnt), 32'(WIN));
    send(17'h00500, 8'h23);
    idle(8);
    send(17'h00501, 8'h24);
    check("R3 refill strobe", 32'(load_stb_o), 32'd1);
    cnt = 0;
    for (int k = 0; k < 40; k++) begin
      if (page_load_en_o) cnt++;
      @(negedge clk);
    end
    check("R3 window after refill", 32'(cnt), 32'(WIN));

    // R9 lockout length, R12 protection persists
    send(17'h05555, 8'hAA); send(17'h02AAA, 8'h55); send(17'h05555, 8'hA0);
    idle(WIN + 4);
    check("R12 protect after window", 32'({protect_o, page_load_en_o}), 32'b10);
    send(17'h00600, 8'h33);
    check("R9 rejected no strobe", 32'(load_stb_o), 32'd0);
    cnt = 0;
    for (int k = 0; k < 40; k++) begin
      if (lockout_o) cnt++;
      @(negedge clk);
    end
    check("R9 lockout length", 32'(cnt), 32'(LOCK));

    // R1 reset clears held state
    send(17'h05555, 8'hAA); send(17'h02AAA, 8'h55); send(17'h05555, 8'h90);
    @(negedge clk); rst = 1'b1;
    idle(2); rst = 1'b0;
    idle(1);
    check("R1 reset clears state", 32'(flags()), 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule